// File: doc/BRIEF.md
# Multi-mode 16-bit timebase counter

This block is the shared timebase of a timer unit. A 16-bit count advances on a tick that is derived from one of four clock-enable sources. The chosen source is divided by 1, 2, 4 or 8 before it reaches the count. A 2-bit mode field selects how the count behaves: it can halt, count up to a period value and wrap, run freely across the full 16-bit range, or run as a triangle that goes up to the period value and back down to zero.

Capture/compare channels that sit beside this block read the count and two events. The first event is a strobe that is high while the count equals the period value. The second is a one-cycle zero/overflow pulse. A sticky overflow flag, gated by an enable, forms the interrupt request. Software uses a clear strobe to restart the timebase and a separate strobe to acknowledge the flag.

Top module: `tmr16_top`

## Requirements
- R1: With mode 00 the count holds its value, whatever the tick sources do.
- R2: With mode 01 the count steps 0,1,...,P (P = period_i) and then returns to 0. If the count is already at or above P, the next tick returns it to 0.
- R3: With mode 10 the count steps up through 0xFFFF and then wraps to 0.
- R4: With mode 11 the count rises to P, turns and falls to 0, then rises again (P=4 gives 0,1,2,3,4,3,2,1,0,1...).
- R5: div_i selects how many selected enables are needed per tick: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
- R6: src_i selects clk_en_i[src_i] as the tick source. The other three enable bits have no effect.
- R7: A one-cycle clear_i zeroes the count, the divider phase and the direction (the next tick counts up). Clear wins over a tick in the same cycle.
- R8: A wrap to 0 (mode 01 or 10) or a downward arrival at 0 (mode 11) raises wrap_o for exactly one cycle, while count_o is 0.
- R9: flag_o sets on the same edge as each R8 event and stays set until flag_clr_i. When a new event and flag_clr_i fall in the same cycle, the flag stays set.
- R10: irq_o is high exactly when flag_o and irq_en_i are both high.
- R11: period_hit_o is high while count_o equals period_i and the mode is not 00.
- R12: After reset, count_o, wrap_o, flag_o and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 4 | Four clock-enable tick sources |
| src_i | input | 2 | Tick source select |
| div_i | input | 2 | Divider select (1/2/4/8) |
| mode_i | input | 2 | Counting mode |
| period_i | input | 16 | Period value (compare 0) |
| clear_i | input | 1 | Timebase clear strobe |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Overflow flag acknowledge strobe |
| count_o | output | 16 | Current count |
| period_hit_o | output | 1 | Count equals period |
| wrap_o | output | 1 | One-cycle zero/overflow pulse |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can act in the same cycle. In the first, a fresh wrap event meets a software flag acknowledge. In the second, a clear strobe meets a live tick. The bench raises flag_clr_i on the exact cycle in which an up-mode count of period 2 wraps, and expects the flag to read 1 afterwards. A later acknowledge with no event present must then drop the flag. For the second pair, the bench holds clear_i high while ticks keep arriving and expects a count of 0 on the following cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_TRI  = 2'b11
  } mode_e;
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int N_SRC = 4,
  parameter int DIV_W = 2,
  localparam int SRC_W = $clog2(N_SRC),
  localparam int PH_W  = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] en_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clear_i,
  output logic             tick_o
);
  logic [PH_W-1:0] phase_q, lim;
  logic            sel_en;

  assign sel_en = en_i[src_i];

  // limit = 2^div - 1, as a thermometer of ones
  always_comb begin
    lim = '0;
    for (int i = 0; i < PH_W; i++)
      if (i < int'(div_i)) lim[i] = 1'b1;
  end

  assign tick_o = sel_en && (phase_q == lim) && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (clear_i) phase_q <= '0;
    else if (sel_en)  phase_q <= (phase_q == lim) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             evt_o,
  output logic             wrap_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d, evt, wrap_q;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    evt    = 1'b0;
    if (tick_i) begin
      unique case (mode_i)
        MODE_HALT: ;
        MODE_UP: begin
          if (cnt_q >= period_i) begin
            cnt_d = '0;
            evt   = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        MODE_CONT: begin
          cnt_d = cnt_q + 1'b1;
          evt   = &cnt_q;
        end
        MODE_TRI: begin
          if (!down_q) begin
            if (cnt_q >= period_i) begin
              if (cnt_q != '0) begin
                cnt_d  = cnt_q - 1'b1;
                down_d = (cnt_q != 1);
                evt    = (cnt_q == 1);
              end
            end else cnt_d = cnt_q + 1'b1;
          end else if (cnt_q == '0) begin
            down_d = 1'b0;
          end else begin
            cnt_d  = cnt_q - 1'b1;
            down_d = (cnt_q != 1);
            evt    = (cnt_q == 1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      wrap_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      wrap_q <= evt;
    end
  end

  assign count_o = cnt_q;
  assign evt_o   = evt && !clear_i;
  assign wrap_o  = wrap_q;
  assign hit_o   = (mode_i != MODE_HALT) && (cnt_q == period_i);
endmodule

// File: rtl/tmr16_flag.sv
module tmr16_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // a new event outranks an acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_SRC = 4,
  parameter int DIV_W = 2,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] clk_en_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             clear_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             period_hit_o,
  output logic             wrap_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic  tick, evt;
  mode_e mode;

  assign mode = mode_e'(mode_i);

  tmr16_prescale #(.N_SRC(N_SRC), .DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .en_i(clk_en_i), .src_i, .div_i, .clear_i, .tick_o(tick)
  );

  tmr16_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .clear_i, .mode_i(mode), .period_i,
    .count_o, .evt_o(evt), .wrap_o, .hit_o(period_hit_o)
  );

  tmr16_flag u_flag (
    .clk_i, .rst_ni, .set_i(evt), .clr_i(flag_clr_i), .en_i(irq_en_i),
    .flag_o, .irq_o
  );
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             clear_i,
  input logic             irq_en_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             wrap_o,
  input logic             flag_o,
  input logic             irq_o
);
  assert_halt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !clear_i) |=> $stable(count_o));

  assert_cont_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !clear_i && (&count_o)) |=> (count_o == '0 || (&count_o)));

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0 && !wrap_o));

  assert_wrap_at_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (count_o == '0 && flag_o));

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));
endmodule

bind tmr16_top tmr16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .mode_i, .clear_i, .irq_en_i, .flag_clr_i,
  .count_o, .wrap_o, .flag_o, .irq_o
);

// File: tb/sim_tmr16_top.sv
`timescale 1ns/1ps
module sim_tmr16_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  en = 4'hF;
  logic [1:0]  src = 2'd0, div = 2'd0, mode = 2'd0;
  logic [15:0] per = 16'd0;
  logic        clr = 1'b0, ien = 1'b0, fclr = 1'b0;
  logic [15:0] cnt;
  logic        hit, wrap, flag, irq;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tmr16_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .src_i(src), .div_i(div),
    .mode_i(mode), .period_i(per), .clear_i(clr), .irq_en_i(ien),
    .flag_clr_i(fclr), .count_o(cnt), .period_hit_o(hit), .wrap_o(wrap),
    .flag_o(flag), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  div;
    logic [15:0] per;
    logic [31:0] n;
    logic [15:0] cnt;
    logic        flag;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{2'b01, 2'b00, 16'd5,   32'd3,  16'd3, 1'b0},  // R2
    '{2'b01, 2'b00, 16'd5,   32'd6,  16'd0, 1'b1},  // R2 wrap
    '{2'b01, 2'b00, 16'd5,   32'd8,  16'd2, 1'b1},  // R2
    '{2'b10, 2'b00, 16'd5,   32'd10, 16'd10, 1'b0}, // R3
    '{2'b11, 2'b00, 16'd4,   32'd6,  16'd2, 1'b0},  // R4 falling
    '{2'b11, 2'b00, 16'd4,   32'd8,  16'd0, 1'b1},  // R4 bottom
    '{2'b11, 2'b00, 16'd4,   32'd9,  16'd1, 1'b1},  // R4 rising again
    '{2'b01, 2'b01, 16'd100, 32'd10, 16'd5, 1'b0},  // R5 div2
    '{2'b01, 2'b11, 16'd100, 32'd20, 16'd2, 1'b0},  // R5 div8
    '{2'b01, 2'b10, 16'd100, 32'd3,  16'd0, 1'b0},  // R5 div4
    '{2'b00, 2'b00, 16'd5,   32'd10, 16'd0, 1'b0}   // R1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic restart();
    clr = 1'b1; fclr = 1'b1;
    @(negedge clk);
    clr = 1'b0; fclr = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run(3);
    chk("R12 count", cnt, 0); chk("R12 wrap", wrap, 0);
    chk("R12 flag", flag, 0); chk("R12 irq", irq, 0);
    rst_n = 1'b1;
    run(1);

    foreach (VECS[i]) begin
      mode = VECS[i].mode; div = VECS[i].div; per = VECS[i].per;
      restart();
      run(int'(VECS[i].n));
      chk($sformatf("R1-5 vec%0d count", i), cnt, VECS[i].cnt);
      chk($sformatf("R9 vec%0d flag", i), flag, VECS[i].flag);
    end

    // R3 / R8: full-range wrap
    mode = 2'b10; div = 2'd0; restart();
    run(65535);
    chk("R3 top", cnt, 16'hFFFF);
    run(1);
    chk("R3 wrapped", cnt, 0); chk("R8 pulse", wrap, 1); chk("R9 set", flag, 1);
    run(1);
    chk("R8 one cycle", wrap, 0); chk("R3 resume", cnt, 1);

    // R11 period hit
    mode = 2'b01; per = 16'd3; restart();
    run(3);
    chk("R11 hit", hit, 1);
    mode = 2'b00; #1;
    chk("R11 halt no hit", hit, 0);
    mode = 2'b01;
    run(1);
    chk("R11 after wrap", hit, 0);

    // R9 / R10 same-cycle set and acknowledge
    per = 16'd2; restart();
    run(2);
    fclr = 1'b1;
    run(1);
    fclr = 1'b0;
    chk("R9 set beats clear", flag, 1);
    ien = 1'b0; #1; chk("R10 gated off", irq, 0);
    ien = 1'b1; #1; chk("R10 on", irq, 1);
    mode = 2'b00; fclr = 1'b1;
    run(1);
    fclr = 1'b0;
    chk("R9 acknowledge", flag, 0); chk("R10 drop", irq, 0);

    // R7 clear wins over tick
    mode = 2'b10; restart();
    run(5);
    clr = 1'b1;
    run(1);
    clr = 1'b0;
    chk("R7 clear wins", cnt, 0);
    run(1);
    chk("R7 restart", cnt, 1);
    // R7 divider phase
    div = 2'b10; restart();
    run(3);
    restart();
    run(3);
    chk("R7 phase zeroed", cnt, 0);
    run(1);
    chk("R7 phase tick", cnt, 1);
    // R7 direction
    div = 2'b00; mode = 2'b11; per = 16'd3; restart();
    run(5);
    chk("R4 falling", cnt, 1);
    restart();
    run(2);
    chk("R7 direction up", cnt, 2);

    // R6 source select
    mode = 2'b10; src = 2'd2; en = 4'b1011; restart();
    run(5);
    chk("R6 others ignored", cnt, 0);
    en = 4'b0100;
    run(5);
    chk("R6 selected", cnt, 5);
    src = 2'd0; en = 4'hF;

    // R2 period lowered below count
    mode = 2'b01; per = 16'd20; restart();
    run(10);
    chk("R2 mid", cnt, 10);
    per = 16'd4;
    run(1);
    chk("R2 forced wrap", cnt, 0); chk("R9 forced wrap flag", flag, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule